// File: doc/BRIEF.md
# Byte-to-word ATA bridge

This block lets an 8-bit host bus drive a 16-bit parallel ATA disk port. It claims a 16-byte I/O window whose base is picked by a strap input. Most offsets in the window pass straight through to a disk register as single-byte cycles. The 16-bit data register is the exception. It is reached as two host byte accesses that are paired through an internal high-byte holding register.

When the host writes the data offset, the disk receives one word. The written byte forms the low half and the holding register forms the high half. When the host reads the data offset, the disk supplies one word. The low half goes back to the host and the high half is parked in the holding register, where a later read of offset 8 collects it. The order is therefore asymmetric: on writes the host loads the high byte first, and on reads it fetches the high byte second.

Every disk access is a fixed sequence. The address and chip select are set up one clock ahead of the strobe, the strobe stays low for a parameterised number of clocks, and the address and chip select are held for one clock after it. The host waits on a ready output throughout. The block also decodes a memory window for an option ROM.

Top module: `byte_ata_bridge`

## Requirements
- R1: A host request is a one-clock pulse of `h_cs` with exactly one of `h_rd`/`h_wr`, sampled while `h_ready` is high. It is accepted only when `h_addr[9:4]` equals bits [9:4] of the base: 0x300 when `alt_cfg`=0, or 0x360 when `alt_cfg`=1. Any other request causes no disk cycle.
- R2: A write to offset 0 makes one disk write with `d_cs0_n` low and `d_addr`=0. The word driven is {holding register, written byte}.
- R3: A read of offset 0 makes one disk read with `d_cs0_n` low and `d_addr`=0. `h_rdata` gets `d_data[7:0]`, and the holding register gets `d_data[15:8]`.
- R4: A write to offset 8 loads the holding register. A read of offset 8 returns the holding register. Neither access starts a disk cycle.
- R5: Offsets 1 to 7 make one disk cycle with `d_cs0_n` low and `d_addr` equal to the offset. A write drives {0x00, byte}, and a read returns `d_data[7:0]`.
- R6: Offset 0xE makes one disk cycle with `d_cs1_n` low and `d_addr`=6. The two chip selects are never low together.
- R7: Reads of offsets 9 to 0xD and 0xF return 0xFF. Writes to those offsets are dropped, and no access to them starts a disk cycle.
- R8: After reset, the holding register and `h_rdata` are 0, `h_ready` is 1, and both strobes and both chip selects are high.
- R9: A disk cycle keeps its chip select low for STROBE_CLKS+2 clocks. Its single strobe (`d_rd_n` or `d_wr_n`) is low for exactly STROBE_CLKS clocks, starting one clock after the select falls.
- R10: `h_ready` is low for STROBE_CLKS+2 clocks after a disk request is accepted. Requests made while it is low are ignored.
- R11: `d_data` is driven only while `d_wr_n` is low and is high-impedance otherwise. Only one strobe is low at a time.
- R12: `rom_sel` is high for `mem_addr` in 0xC8000 to 0xCBFFF when `alt_cfg`=0, and in 0xC8000 to 0xCFFFF when `alt_cfg`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_cfg | input | 1 | Strap: selects the alternate I/O base and the larger ROM window |
| h_addr | input | 10 | Host I/O address |
| h_wdata | input | 8 | Host write data |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_cs | input | 1 | Host chip select |
| h_rdata | output | 8 | Registered host read data |
| h_ready | output | 1 | High when a new request may be issued |
| mem_addr | input | 20 | Host memory address |
| rom_sel | output | 1 | Option ROM window hit |
| d_cs0_n | output | 1 | Disk command-block select, active low |
| d_cs1_n | output | 1 | Disk control-block select, active low |
| d_addr | output | 3 | Disk register index |
| d_data | inout | 16 | Disk data bus |
| d_rd_n | output | 1 | Disk read strobe, active low |
| d_wr_n | output | 1 | Disk write strobe, active low |

## Verification
The assertions take for granted that the host pulses one request at a time with a single strobe, and that `alt_cfg` stays fixed while a disk cycle is running. They also assume the disk drives `d_data` only while `d_rd_n` is low. The bench's host task raises `h_cs` together with exactly one of `h_rd`/`h_wr` for a single clock, and changes the strap only between accesses. Its disk model places a word on the bus only during read strobes. The one deliberate departure from this is a second request issued while `h_ready` is low, which the design must drop.

// File: rtl/byte_ata_bridge.sv
module byte_ata_bridge #(
  parameter int          STROBE_CLKS = 3,       // at least 3
  parameter logic [9:0]  STD_BASE    = 10'h300,
  parameter logic [9:0]  ALT_BASE    = 10'h360,
  parameter logic [19:0] ROM_BASE    = 20'hC8000,
  parameter int          STD_ROM_KB  = 16,
  parameter int          ALT_ROM_KB  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alt_cfg,
  input  logic [9:0]  h_addr,
  input  logic [7:0]  h_wdata,
  input  logic        h_rd,
  input  logic        h_wr,
  input  logic        h_cs,
  output logic [7:0]  h_rdata,
  output logic        h_ready,
  input  logic [19:0] mem_addr,
  output logic        rom_sel,
  output logic        d_cs0_n,
  output logic        d_cs1_n,
  output logic [2:0]  d_addr,
  inout  wire  [15:0] d_data,
  output logic        d_rd_n,
  output logic        d_wr_n
);
  localparam int CW = $clog2(STROBE_CLKS);
  localparam int LW = $clog2(STROBE_CLKS + 1);
  localparam logic [20:0] STD_END = {1'b0, ROM_BASE} + 21'(STD_ROM_KB * 1024);
  localparam logic [20:0] ALT_END = {1'b0, ROM_BASE} + 21'(ALT_ROM_KB * 1024);
  localparam logic [3:0] OFF_CTL = 4'hE;
  localparam logic [3:0] OFF_HI  = 4'h8;

  typedef enum logic [1:0] {IDLE, SETUP, STROBE, HOLD} st_t;

  st_t            st;
  logic [CW-1:0]  cnt;
  logic [7:0]     hi_q;
  logic [7:0]     wbyte_q;
  logic [3:0]     off_q;
  logic           is_wr_q;

  wire [9:0] base    = alt_cfg ? ALT_BASE : STD_BASE;
  wire [3:0] off     = h_addr[3:0];
  wire       hit     = h_cs && (h_rd ^ h_wr) && (h_addr[9:4] == base[9:4]);
  wire       to_disk = (off <= 4'd7) || (off == OFF_CTL);
  wire       go      = (st == IDLE) && hit;
  wire       busy    = (st != IDLE);
  wire       strobe  = (st == STROBE);
  wire       ctl_sel = (off_q == OFF_CTL);
  wire [15:0] wword  = (off_q == 4'd0) ? {hi_q, wbyte_q} : {8'h00, wbyte_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      hi_q    <= 8'h00;
      h_rdata <= 8'h00;
      wbyte_q <= 8'h00;
      off_q   <= 4'h0;
      is_wr_q <= 1'b0;
    end else begin
      case (st)
        IDLE: if (go) begin
          if (to_disk) begin
            st      <= SETUP;
            off_q   <= off;
            is_wr_q <= h_wr;
            wbyte_q <= h_wdata;
          end else if (off == OFF_HI) begin
            if (h_wr) hi_q <= h_wdata;
            else      h_rdata <= hi_q;
          end else if (h_rd) begin
            h_rdata <= 8'hFF;
          end
        end
        SETUP: begin
          st  <= STROBE;
          cnt <= '0;
        end
        STROBE: begin
          if (cnt == CW'(STROBE_CLKS - 1)) begin
            st <= HOLD;
            if (!is_wr_q) begin
              h_rdata <= d_data[7:0];
              if (off_q == 4'd0) hi_q <= d_data[15:8];
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign h_ready = !busy;
  assign d_cs0_n = !(busy && !ctl_sel);
  assign d_cs1_n = !(busy && ctl_sel);
  assign d_addr  = ctl_sel ? 3'd6 : off_q[2:0];
  assign d_rd_n  = !(strobe && !is_wr_q);
  assign d_wr_n  = !(strobe && is_wr_q);
  assign d_data  = (strobe && is_wr_q) ? wword : 16'hzzzz;

  assign rom_sel = ({1'b0, mem_addr} >= {1'b0, ROM_BASE}) &&
                   ({1'b0, mem_addr} < (alt_cfg ? ALT_END : STD_END));

  logic [LW-1:0] low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                low_cnt <= '0;
    else if (!d_rd_n || !d_wr_n) low_cnt <= low_cnt + 1'b1;
    else                       low_cnt <= '0;
  end

  a_r9_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(d_rd_n) || $fell(d_wr_n)) |-> $past(!d_cs0_n || !d_cs1_n));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(d_rd_n) || $rose(d_wr_n)) |-> (!d_cs0_n || !d_cs1_n));
  a_r9_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(d_rd_n) || $rose(d_wr_n)) |-> (low_cnt == LW'(STROBE_CLKS)));
  a_r6_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!d_cs0_n && !d_cs1_n));
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!d_rd_n && !d_wr_n));
  a_r10_ready_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_ready) |-> (d_rd_n && d_wr_n && $past(d_rd_n && d_wr_n)));
  a_r7_local_no_disk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_ready && hit && !to_disk) |=> (d_cs0_n && d_cs1_n && h_ready));
endmodule

// File: tb/byte_ata_bridge_tb.sv
module byte_ata_bridge_tb;
  localparam int N = 3;

  logic        clk = 0, rst_n = 0, alt_cfg = 0;
  logic [9:0]  h_addr = '0;
  logic [7:0]  h_wdata = '0;
  logic        h_rd = 0, h_wr = 0, h_cs = 0;
  logic [7:0]  h_rdata;
  logic        h_ready;
  logic [19:0] mem_addr = '0;
  logic        rom_sel;
  logic        d_cs0_n, d_cs1_n, d_rd_n, d_wr_n;
  logic [2:0]  d_addr;
  wire  [15:0] d_data;

  always #4 clk = ~clk;

  byte_ata_bridge #(.STROBE_CLKS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .alt_cfg(alt_cfg),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr), .h_cs(h_cs),
    .h_rdata(h_rdata), .h_ready(h_ready), .mem_addr(mem_addr), .rom_sel(rom_sel),
    .d_cs0_n(d_cs0_n), .d_cs1_n(d_cs1_n), .d_addr(d_addr), .d_data(d_data),
    .d_rd_n(d_rd_n), .d_wr_n(d_wr_n));

  // disk model
  logic [15:0] dmem [8];
  wire  [15:0] rd_word = !d_cs1_n ? 16'h0050 : dmem[d_addr];
  assign d_data = !d_rd_n ? rd_word : 16'hzzzz;
  always @(posedge clk) if (!d_wr_n && !d_cs0_n) dmem[d_addr] <= d_data;

  // bus monitor
  int cyc_cnt = 0, cs_cnt = 0, stb_cnt = 0;
  logic prev_stb = 0;
  logic [1:0]  last_cs = '0;
  logic [2:0]  last_addr = '0;
  logic [15:0] last_dw = '0;
  always @(negedge clk) begin
    logic stb;
    stb = !d_rd_n || !d_wr_n;
    if (stb && !prev_stb) cyc_cnt++;
    if (stb) begin
      stb_cnt++;
      last_cs = {!d_cs1_n, !d_cs0_n};
      last_addr = d_addr;
      if (!d_wr_n) last_dw = d_data;
    end
    if (!d_cs0_n || !d_cs1_n) cs_cnt++;
    prev_stb = stb;
  end

  int tests = 0, fails = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host(input bit wr, input logic [9:0] a, input logic [7:0] wd,
                      output logic [7:0] rd, output int busy);
    @(negedge clk);
    h_cs = 1; h_wr = wr; h_rd = !wr; h_addr = a; h_wdata = wd;
    @(negedge clk);
    h_cs = 0; h_wr = 0; h_rd = 0;
    busy = 0;
    while (!h_ready) begin busy++; @(negedge clk); end
    rd = h_rdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [3:0]  off;
    logic [7:0]  wd;
    logic [7:0]  er;
    logic        cyc;
    logic [15:0] dw;
    logic [1:0]  cs;
    logic [2:0]  ad;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'h8, 8'hBE, 8'h00, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b1, 4'h0, 8'hEF, 8'h00, 1'b1, 16'hBEEF, 2'b01, 3'd0},
    '{1'b0, 4'h8, 8'h00, 8'hBE, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b1, 4'h3, 8'h5A, 8'h00, 1'b1, 16'h005A, 2'b01, 3'd3},
    '{1'b0, 4'h3, 8'h00, 8'h5A, 1'b1, 16'h0000, 2'b01, 3'd3},
    '{1'b1, 4'h8, 8'hC3, 8'h00, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b1, 4'h0, 8'h11, 8'h00, 1'b1, 16'hC311, 2'b01, 3'd0},
    '{1'b1, 4'h8, 8'h00, 8'h00, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b0, 4'h0, 8'h00, 8'h11, 1'b1, 16'h0000, 2'b01, 3'd0},
    '{1'b0, 4'h8, 8'h00, 8'hC3, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b1, 4'hE, 8'h04, 8'h00, 1'b1, 16'h0004, 2'b10, 3'd6},
    '{1'b0, 4'hE, 8'h00, 8'h50, 1'b1, 16'h0000, 2'b10, 3'd6},
    '{1'b1, 4'h9, 8'h77, 8'h00, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b0, 4'h9, 8'h00, 8'hFF, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b0, 4'hF, 8'h00, 8'hFF, 1'b0, 16'h0000, 2'b00, 3'd0},
    '{1'b1, 4'h7, 8'hEC, 8'h00, 1'b1, 16'h00EC, 2'b01, 3'd7},
    '{1'b0, 4'h7, 8'h00, 8'hEC, 1'b1, 16'h0000, 2'b01, 3'd7}
  };

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int busy, c0;
    for (int i = 0; i < 8; i++) dmem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reset state
    chk("R8 ready", h_ready, 1);
    chk("R8 strobes/selects", {d_rd_n, d_wr_n, d_cs0_n, d_cs1_n}, 4'hF);
    chk("R8 rdata", h_rdata, 0);
    chk("R11 bus idle z", d_data === 16'hzzzz, 1);
    host(0, 10'h308, 0, rd, busy);
    chk("R8 latch reset", rd, 0);

    // vector table (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      c0 = cyc_cnt;
      host(VEC[i].wr, {6'h30, VEC[i].off}, VEC[i].wd, rd, busy);
      chk($sformatf("R4/R7 vec%0d disk cycles", i), cyc_cnt - c0, VEC[i].cyc);
      if (!VEC[i].wr) chk($sformatf("R3/R5 vec%0d read data", i), rd, VEC[i].er);
      if (VEC[i].cyc) begin
        chk($sformatf("R6 vec%0d selects", i), last_cs, VEC[i].cs);
        chk($sformatf("R5 vec%0d disk addr", i), last_addr, VEC[i].ad);
        if (VEC[i].wr) chk($sformatf("R2 vec%0d disk word", i), last_dw, VEC[i].dw);
      end
    end

    // R9 R10 timing of one write
    cs_cnt = 0; stb_cnt = 0;
    host(1, 10'h302, 8'h21, rd, busy);
    chk("R9 strobe clocks", stb_cnt, N);
    chk("R9 select clocks", cs_cnt, N + 2);
    chk("R10 busy clocks", busy, N + 2);
    chk("R11 bus released", d_data === 16'hzzzz, 1);

    // R10 request while busy is dropped
    c0 = cyc_cnt;
    @(negedge clk); h_cs = 1; h_wr = 1; h_addr = 10'h303; h_wdata = 8'h99;
    @(negedge clk); h_cs = 1; h_wr = 1; h_addr = 10'h304; h_wdata = 8'h44;
    @(negedge clk); h_cs = 0; h_wr = 0;
    while (!h_ready) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R10 one cycle only", cyc_cnt - c0, 1);
    chk("R10 busy request dropped", last_addr, 3);

    // R1 window decode
    c0 = cyc_cnt;
    host(1, 10'h310, 8'h01, rd, busy);
    host(1, 10'h363, 8'h01, rd, busy);
    chk("R1 outside window ignored", cyc_cnt - c0, 0);
    alt_cfg = 1;
    host(1, 10'h303, 8'h01, rd, busy);
    chk("R1 std base off when alt", cyc_cnt - c0, 0);
    host(1, 10'h365, 8'h3C, rd, busy);
    chk("R1 alt base hits", cyc_cnt - c0, 1);
    chk("R1 alt base word", last_dw, 16'h003C);

    // R12 ROM window
    alt_cfg = 0;
    mem_addr = 20'hC8000; @(negedge clk); chk("R12 std start", rom_sel, 1);
    mem_addr = 20'hCBFFF; @(negedge clk); chk("R12 std last", rom_sel, 1);
    mem_addr = 20'hCC000; @(negedge clk); chk("R12 std past", rom_sel, 0);
    mem_addr = 20'hC7FFF; @(negedge clk); chk("R12 below", rom_sel, 0);
    alt_cfg = 1;
    mem_addr = 20'hCFFFF; @(negedge clk); chk("R12 alt last", rom_sel, 1);
    mem_addr = 20'hD0000; @(negedge clk); chk("R12 alt past", rom_sel, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule